// File: doc/BRIEF.md
# Programmable Raster Timing Generator

This block produces the timing signals that frame a progressive video raster: horizontal and vertical sync, horizontal and vertical blanking, an active-video flag, and a small set of frame-sync pulses. A pixel counter and a line counter run through a programmed total, and every output is decoded from their values against a programmed window. The active region always starts at count zero on both axes.

Software programs the block through a plain write/read register port. Timing values land in a pending bank and move into a working bank only while the generator is stopped, or at the last enabled cycle of a frame, so a frame is never partly retimed. The generator can free-run on every pixel clock or, in follower mode, advance only in cycles where a clock-enable from the downstream stream-to-video bridge is high. Frame-sync 0 is fixed at the first active pixel. The remaining pulses sit at programmable (line, pixel) points.

Top module: `vtg_top`

## Requirements
- R1: After reset the generator is stopped, the active flag, both blanks and all frame-sync outputs are low, syncs sit at their inactive level (high-active, so low), and the horizontal total register (address 1) reads 2200.
- R2: Registers read back the last value written. Addresses: 0 control (bit0 run, bit1 follower mode, bit2 horizontal sync active-low, bit3 vertical sync active-low), 1 h total, 2 v total, 3 h active, 4 v active, 5/6 hsync begin/end, 7/8 vsync begin/end, 9/10 hblank begin/end, 11/12 vblank begin/end, 16+k frame-sync k position with pixel in bits 15:0 and line in bits 31:16 (k from 1). Unmapped addresses read 0.
- R3: The pixel counter counts 0 to h total minus 1 and then wraps, and hsync is asserted while hsync begin <= pixel < hsync end.
- R4: Active video is high when pixel < h active and line < v active, and hblank is high while hblank begin <= pixel < hblank end.
- R5: The line counter advances on a pixel wrap, wraps after v total lines, and vsync and vblank are asserted for begin <= line < end.
- R6: Control bits 2 and 3 invert the asserted level of hsync and vsync respectively.
- R7: Frame-sync 0 pulses for exactly one advancing cycle at pixel 0, line 0, once per frame.
- R8: Frame-sync k (k >= 1) pulses for one advancing cycle at its programmed line and pixel, once per frame.
- R9: In follower mode the counters advance only in cycles with ce_i high, and frame-sync pulses occur only in such cycles. In free-run mode ce_i is ignored.
- R10: Timing, mode and polarity writes made while running take effect only from the first cycle of the next frame.
- R11: Clearing run forces every output idle and returns both counters to 0. Setting run starts the raster at pixel 0, line 0 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ce_i | input | 1 | Advance enable from the downstream bridge (follower mode) |
| we_i | input | 1 | Register write strobe |
| addr_i | input | AW | Register word address |
| wdata_i | input | 32 | Register write data |
| rdata_o | output | 32 | Register read data (pending bank) |
| hsync_o | output | 1 | Horizontal sync |
| vsync_o | output | 1 | Vertical sync |
| hblank_o | output | 1 | Horizontal blanking |
| vblank_o | output | 1 | Vertical blanking |
| active_o | output | 1 | Active video |
| fsync_o | output | NUM_FS | Frame-sync pulses, bit 0 at the first active pixel |

## Verification
The bench keeps a cycle model of both counters and both register banks, so it catches an off-by-one on a total, which would stretch or shorten each line or frame, and a window decoded as inclusive of its end, which would widen sync and blank by a pixel. A timing write made in the middle of a frame targets the case where new values are applied at once: the rest of that frame would be retimed and the model would diverge before the frame end. An irregular clock-enable pattern in follower mode finds counters or pulses that ignore the enable: pixels would be skipped, or frame-sync would fire on a held cycle. Frame-sync points placed inside blanking, and counts of pulses per frame, expose a pulse that repeats or never fires.

// File: rtl/vtg_pkg.sv
package vtg_pkg;
  localparam int TW = 16;

  typedef struct packed {
    logic [TW-1:0] h_total;
    logic [TW-1:0] v_total;
    logic [TW-1:0] h_act;
    logic [TW-1:0] v_act;
    logic [TW-1:0] hs_beg;
    logic [TW-1:0] hs_end;
    logic [TW-1:0] vs_beg;
    logic [TW-1:0] vs_end;
    logic [TW-1:0] hb_beg;
    logic [TW-1:0] hb_end;
    logic [TW-1:0] vb_beg;
    logic [TW-1:0] vb_end;
    logic          slave;
    logic          hs_low;
    logic          vs_low;
  } timing_t;

  localparam timing_t TIMING_RST = '{
    h_total: 16'd2200, v_total: 16'd1125,
    h_act:   16'd1920, v_act:   16'd1080,
    hs_beg:  16'd2008, hs_end:  16'd2052,
    vs_beg:  16'd1084, vs_end:  16'd1089,
    hb_beg:  16'd1920, hb_end:  16'd2200,
    vb_beg:  16'd1080, vb_end:  16'd1125,
    slave:   1'b0, hs_low: 1'b0, vs_low: 1'b0
  };

  localparam int RA_CTRL    = 0;
  localparam int RA_HTOT    = 1;
  localparam int RA_VTOT    = 2;
  localparam int RA_HACT    = 3;
  localparam int RA_VACT    = 4;
  localparam int RA_HS_BEG  = 5;
  localparam int RA_HS_END  = 6;
  localparam int RA_VS_BEG  = 7;
  localparam int RA_VS_END  = 8;
  localparam int RA_HB_BEG  = 9;
  localparam int RA_HB_END  = 10;
  localparam int RA_VB_BEG  = 11;
  localparam int RA_VB_END  = 12;
  localparam int RA_FS_BASE = 16;
endpackage

// File: rtl/vtg_regs.sv
module vtg_regs
  import vtg_pkg::*;
#(
  parameter int AW     = 5,
  parameter int NUM_FS = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [31:0]   wdata_i,
  output logic [31:0]   rdata_o,
  input  logic          latch_i,
  output logic          run_o,
  output timing_t       cfg_o,
  output logic [TW-1:0] fs_pix_o  [NUM_FS],
  output logic [TW-1:0] fs_line_o [NUM_FS]
);
  timing_t cfg_p, cfg_s;
  logic    run_q;
  logic [TW-1:0] fs_pix_p  [NUM_FS];
  logic [TW-1:0] fs_line_p [NUM_FS];

  function automatic logic hit(input logic [AW-1:0] a, input int idx);
    return a == AW'(idx);
  endfunction

  // pending bank
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_p <= TIMING_RST;
      run_q <= 1'b0;
    end else if (we_i) begin
      if (hit(addr_i, RA_CTRL)) begin
        run_q        <= wdata_i[0];
        cfg_p.slave  <= wdata_i[1];
        cfg_p.hs_low <= wdata_i[2];
        cfg_p.vs_low <= wdata_i[3];
      end
      if (hit(addr_i, RA_HTOT))   cfg_p.h_total <= wdata_i[TW-1:0];
      if (hit(addr_i, RA_VTOT))   cfg_p.v_total <= wdata_i[TW-1:0];
      if (hit(addr_i, RA_HACT))   cfg_p.h_act   <= wdata_i[TW-1:0];
      if (hit(addr_i, RA_VACT))   cfg_p.v_act   <= wdata_i[TW-1:0];
      if (hit(addr_i, RA_HS_BEG)) cfg_p.hs_beg  <= wdata_i[TW-1:0];
      if (hit(addr_i, RA_HS_END)) cfg_p.hs_end  <= wdata_i[TW-1:0];
      if (hit(addr_i, RA_VS_BEG)) cfg_p.vs_beg  <= wdata_i[TW-1:0];
      if (hit(addr_i, RA_VS_END)) cfg_p.vs_end  <= wdata_i[TW-1:0];
      if (hit(addr_i, RA_HB_BEG)) cfg_p.hb_beg  <= wdata_i[TW-1:0];
      if (hit(addr_i, RA_HB_END)) cfg_p.hb_end  <= wdata_i[TW-1:0];
      if (hit(addr_i, RA_VB_BEG)) cfg_p.vb_beg  <= wdata_i[TW-1:0];
      if (hit(addr_i, RA_VB_END)) cfg_p.vb_end  <= wdata_i[TW-1:0];
    end
  end

  // working bank
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cfg_s <= TIMING_RST;
    else if (latch_i) cfg_s <= cfg_p;
  end

  for (genvar g = 0; g < NUM_FS; g++) begin : g_fs
    if (g == 0) begin : g_fixed
      assign fs_pix_p[g]  = '0;
      assign fs_line_p[g] = '0;
      assign fs_pix_o[g]  = '0;
      assign fs_line_o[g] = '0;
    end else begin : g_prog
      logic [TW-1:0] pix_p, line_p, pix_s, line_s;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          pix_p  <= '0;
          line_p <= '0;
        end else if (we_i && hit(addr_i, RA_FS_BASE + g)) begin
          pix_p  <= wdata_i[TW-1:0];
          line_p <= wdata_i[TW+15:16];
        end
      end
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          pix_s  <= '0;
          line_s <= '0;
        end else if (latch_i) begin
          pix_s  <= pix_p;
          line_s <= line_p;
        end
      end
      assign fs_pix_p[g]  = pix_p;
      assign fs_line_p[g] = line_p;
      assign fs_pix_o[g]  = pix_s;
      assign fs_line_o[g] = line_s;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (hit(addr_i, RA_CTRL))   rdata_o = {28'b0, cfg_p.vs_low, cfg_p.hs_low, cfg_p.slave, run_q};
    if (hit(addr_i, RA_HTOT))   rdata_o = 32'(cfg_p.h_total);
    if (hit(addr_i, RA_VTOT))   rdata_o = 32'(cfg_p.v_total);
    if (hit(addr_i, RA_HACT))   rdata_o = 32'(cfg_p.h_act);
    if (hit(addr_i, RA_VACT))   rdata_o = 32'(cfg_p.v_act);
    if (hit(addr_i, RA_HS_BEG)) rdata_o = 32'(cfg_p.hs_beg);
    if (hit(addr_i, RA_HS_END)) rdata_o = 32'(cfg_p.hs_end);
    if (hit(addr_i, RA_VS_BEG)) rdata_o = 32'(cfg_p.vs_beg);
    if (hit(addr_i, RA_VS_END)) rdata_o = 32'(cfg_p.vs_end);
    if (hit(addr_i, RA_HB_BEG)) rdata_o = 32'(cfg_p.hb_beg);
    if (hit(addr_i, RA_HB_END)) rdata_o = 32'(cfg_p.hb_end);
    if (hit(addr_i, RA_VB_BEG)) rdata_o = 32'(cfg_p.vb_beg);
    if (hit(addr_i, RA_VB_END)) rdata_o = 32'(cfg_p.vb_end);
    for (int k = 1; k < NUM_FS; k++) begin
      if (hit(addr_i, RA_FS_BASE + k)) rdata_o = {16'(fs_line_p[k]), 16'(fs_pix_p[k])};
    end
  end

  assign run_o = run_q;
  assign cfg_o = cfg_s;
endmodule

// File: rtl/vtg_counter.sv
module vtg_counter
  import vtg_pkg::*;
#(
  parameter int CW = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic          adv_i,
  input  logic [TW-1:0] h_total_i,
  input  logic [TW-1:0] v_total_i,
  output logic [CW-1:0] h_o,
  output logic [CW-1:0] v_o,
  output logic          frame_end_o
);
  logic [CW-1:0] h_q, v_q;
  logic h_last, v_last;

  assign h_last = TW'(h_q) == h_total_i - TW'(1);
  assign v_last = TW'(v_q) == v_total_i - TW'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      h_q <= '0;
      v_q <= '0;
    end else if (!run_i) begin
      h_q <= '0;
      v_q <= '0;
    end else if (adv_i) begin
      if (h_last) begin
        h_q <= '0;
        v_q <= v_last ? '0 : v_q + CW'(1);
      end else begin
        h_q <= h_q + CW'(1);
      end
    end
  end

  assign h_o         = h_q;
  assign v_o         = v_q;
  assign frame_end_o = run_i & adv_i & h_last & v_last;
endmodule

// File: rtl/vtg_window.sv
module vtg_window
  import vtg_pkg::*;
#(
  parameter int CW = 12
) (
  input  logic          run_i,
  input  logic [CW-1:0] h_i,
  input  logic [CW-1:0] v_i,
  input  logic [TW-1:0] h_act_i,
  input  logic [TW-1:0] v_act_i,
  input  logic [TW-1:0] hs_beg_i,
  input  logic [TW-1:0] hs_end_i,
  input  logic [TW-1:0] vs_beg_i,
  input  logic [TW-1:0] vs_end_i,
  input  logic [TW-1:0] hb_beg_i,
  input  logic [TW-1:0] hb_end_i,
  input  logic [TW-1:0] vb_beg_i,
  input  logic [TW-1:0] vb_end_i,
  input  logic          hs_low_i,
  input  logic          vs_low_i,
  output logic          active_o,
  output logic          hblank_o,
  output logic          vblank_o,
  output logic          hsync_o,
  output logic          vsync_o
);
  logic [TW-1:0] h, v;
  assign h = TW'(h_i);
  assign v = TW'(v_i);

  function automatic logic inside_win(input logic [TW-1:0] c, b, e);
    return (c >= b) && (c < e);
  endfunction

  // inactive sync level equals the low-active select bit
  assign active_o = run_i & (h < h_act_i) & (v < v_act_i);
  assign hblank_o = run_i & inside_win(h, hb_beg_i, hb_end_i);
  assign vblank_o = run_i & inside_win(v, vb_beg_i, vb_end_i);
  assign hsync_o  = (run_i & inside_win(h, hs_beg_i, hs_end_i)) ^ hs_low_i;
  assign vsync_o  = (run_i & inside_win(v, vs_beg_i, vs_end_i)) ^ vs_low_i;
endmodule

// File: rtl/vtg_fsync.sv
module vtg_fsync
  import vtg_pkg::*;
#(
  parameter int CW     = 12,
  parameter int NUM_FS = 4
) (
  input  logic              fire_i,
  input  logic [CW-1:0]     h_i,
  input  logic [CW-1:0]     v_i,
  input  logic [TW-1:0]     pix_i  [NUM_FS],
  input  logic [TW-1:0]     line_i [NUM_FS],
  output logic [NUM_FS-1:0] fsync_o
);
  for (genvar g = 0; g < NUM_FS; g++) begin : g_cmp
    assign fsync_o[g] = fire_i & (TW'(h_i) == pix_i[g]) & (TW'(v_i) == line_i[g]);
  end
endmodule

// File: rtl/vtg_top.sv
module vtg_top
  import vtg_pkg::*;
#(
  parameter int AW     = 5,
  parameter int CW     = 12,
  parameter int NUM_FS = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_i,
  input  logic              we_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              hsync_o,
  output logic              vsync_o,
  output logic              hblank_o,
  output logic              vblank_o,
  output logic              active_o,
  output logic [NUM_FS-1:0] fsync_o
);
  timing_t       cfg;
  logic          run, adv, frame_end, latch;
  logic [CW-1:0] h_cnt, v_cnt;
  logic [TW-1:0] fs_pix  [NUM_FS];
  logic [TW-1:0] fs_line [NUM_FS];

  assign adv   = run & (cfg.slave ? ce_i : 1'b1);
  assign latch = ~run | frame_end;

  vtg_regs #(.AW(AW), .NUM_FS(NUM_FS)) regs_i (
    .clk_i, .rst_ni, .we_i, .addr_i, .wdata_i, .rdata_o,
    .latch_i(latch), .run_o(run), .cfg_o(cfg),
    .fs_pix_o(fs_pix), .fs_line_o(fs_line)
  );

  vtg_counter #(.CW(CW)) cnt_i (
    .clk_i, .rst_ni, .run_i(run), .adv_i(adv),
    .h_total_i(cfg.h_total), .v_total_i(cfg.v_total),
    .h_o(h_cnt), .v_o(v_cnt), .frame_end_o(frame_end)
  );

  vtg_window #(.CW(CW)) win_i (
    .run_i(run), .h_i(h_cnt), .v_i(v_cnt),
    .h_act_i(cfg.h_act), .v_act_i(cfg.v_act),
    .hs_beg_i(cfg.hs_beg), .hs_end_i(cfg.hs_end),
    .vs_beg_i(cfg.vs_beg), .vs_end_i(cfg.vs_end),
    .hb_beg_i(cfg.hb_beg), .hb_end_i(cfg.hb_end),
    .vb_beg_i(cfg.vb_beg), .vb_end_i(cfg.vb_end),
    .hs_low_i(cfg.hs_low), .vs_low_i(cfg.vs_low),
    .active_o, .hblank_o, .vblank_o, .hsync_o, .vsync_o
  );

  vtg_fsync #(.CW(CW), .NUM_FS(NUM_FS)) fs_i (
    .fire_i(adv), .h_i(h_cnt), .v_i(v_cnt),
    .pix_i(fs_pix), .line_i(fs_line), .fsync_o
  );
endmodule

// File: rtl/vtg_chk.sv
module vtg_chk
  import vtg_pkg::*;
#(
  parameter int CW     = 12,
  parameter int NUM_FS = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ce_i,
  input logic              run,
  input logic              frame_end,
  input timing_t           cfg,
  input logic [CW-1:0]     h_cnt,
  input logic [CW-1:0]     v_cnt,
  input logic              active_o,
  input logic              hblank_o,
  input logic              vblank_o,
  input logic [NUM_FS-1:0] fsync_o
);
  a_r9_hold_without_ce: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && cfg.slave && !ce_i) |=> ($stable(h_cnt) && $stable(v_cnt)));

  a_r9_fsync_needs_ce: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg.slave && !ce_i) |-> (fsync_o == '0));

  a_r11_idle_outputs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run |-> (!active_o && !hblank_o && !vblank_o && fsync_o == '0));

  a_r11_counters_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run |=> (h_cnt == '0 && v_cnt == '0));

  a_r7_fs0_in_active: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fsync_o[0] |-> active_o);

  a_r10_bank_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && !frame_end) |=> $stable(cfg));

  a_r3_pixel_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && frame_end) |=> (h_cnt == '0 && v_cnt == '0));
endmodule

bind vtg_top vtg_chk #(.CW(CW), .NUM_FS(NUM_FS)) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .ce_i(ce_i), .run(run), .frame_end(frame_end),
  .cfg(cfg), .h_cnt(h_cnt), .v_cnt(v_cnt), .active_o(active_o),
  .hblank_o(hblank_o), .vblank_o(vblank_o), .fsync_o(fsync_o)
);

// File: tb/vtg_top_tb.sv
module vtg_top_tb_top;
  localparam int AW = 5;
  localparam int NFS = 4;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic ce_i = 1'b0;
  logic we_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic hsync_o, vsync_o, hblank_o, vblank_o, active_o;
  logic [NFS-1:0] fsync_o;

  always #10 clk_i = ~clk_i;

  vtg_top #(.AW(AW), .CW(12), .NUM_FS(NFS)) dut_i (.*);

  typedef struct {
    int ht, vt, ha, va, hsb, hse, vsb, vse, hbb, hbe, vbb, vbe;
    bit slave, hlow, vlow;
    int fph[NFS];
    int fpv[NFS];
  } mcfg_t;

  mcfg_t cur, pend;
  bit run_p;
  int mh, mv;
  int n_checks = 0, n_errors = 0;
  int fs_cnt[NFS];
  bit done = 1'b0;

  task automatic check(input bit ok, input string tag, input string msg);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: %s", tag, msg);
    end
  endtask

  function automatic void apply_write(input int a, input logic [31:0] d);
    case (a)
      0: begin run_p = d[0]; pend.slave = d[1]; pend.hlow = d[2]; pend.vlow = d[3]; end
      1: pend.ht = int'(d[15:0]);
      2: pend.vt = int'(d[15:0]);
      3: pend.ha = int'(d[15:0]);
      4: pend.va = int'(d[15:0]);
      5: pend.hsb = int'(d[15:0]);
      6: pend.hse = int'(d[15:0]);
      7: pend.vsb = int'(d[15:0]);
      8: pend.vse = int'(d[15:0]);
      9: pend.hbb = int'(d[15:0]);
      10: pend.hbe = int'(d[15:0]);
      11: pend.vbb = int'(d[15:0]);
      12: pend.vbe = int'(d[15:0]);
      default: if (a > 16 && a < 16 + NFS) begin
        pend.fph[a-16] = int'(d[15:0]);
        pend.fpv[a-16] = int'(d[31:16]);
      end
    endcase
  endfunction

  // one cycle: compare outputs with the model, then advance the model
  task automatic step(input bit ce, input string tag);
    logic [NFS+4:0] exp_v, act_v;
    bit adv;
    logic [NFS-1:0] efs;
    ce_i = ce;
    #1;
    adv = run_p && (cur.slave ? ce : 1'b1);
    for (int k = 0; k < NFS; k++)
      efs[k] = adv && mh == cur.fph[k] && mv == cur.fpv[k];
    exp_v = {efs,
             (run_p && mv >= cur.vsb && mv < cur.vse) ^ cur.vlow,
             (run_p && mh >= cur.hsb && mh < cur.hse) ^ cur.hlow,
             run_p && mv >= cur.vbb && mv < cur.vbe,
             run_p && mh >= cur.hbb && mh < cur.hbe,
             run_p && mh < cur.ha && mv < cur.va};
    act_v = {fsync_o, vsync_o, hsync_o, vblank_o, hblank_o, active_o};
    check(act_v === exp_v, tag,
          $sformatf("pix %0d line %0d {fs,vs,hs,vb,hb,act} actual %b expected %b", mh, mv, act_v, exp_v));
    for (int k = 0; k < NFS; k++) if (fsync_o[k]) fs_cnt[k]++;
    if (!run_p) begin
      mh = 0; mv = 0; cur = pend;
    end else if (adv) begin
      if (mh == cur.ht - 1) begin
        mh = 0;
        if (mv == cur.vt - 1) begin mv = 0; cur = pend; end
        else mv++;
      end else mh++;
    end
    if (we_i) apply_write(int'(addr_i), wdata_i);
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic wr(input int a, input logic [31:0] d, input string tag);
    we_i = 1'b1; addr_i = AW'(a); wdata_i = d;
    step(1'b1, tag);
    we_i = 1'b0;
  endtask

  task automatic rd_check(input int a, input logic [31:0] exp, input string tag);
    addr_i = AW'(a);
    #1;
    check(rdata_o === exp, tag, $sformatf("read addr %0d actual %h expected %h", a, rdata_o, exp));
  endtask

  task automatic t_reset;
    rd_check(1, 32'd2200, "R1");
    rd_check(0, 32'd0, "R1");
    step(1'b1, "R1");
  endtask

  task automatic t_regs;
    wr(1, 10, "R2"); wr(2, 6, "R2"); wr(3, 6, "R2"); wr(4, 4, "R2");
    wr(5, 7, "R2");  wr(6, 9, "R2"); wr(7, 4, "R2"); wr(8, 5, "R2");
    wr(9, 6, "R2");  wr(10, 10, "R2"); wr(11, 4, "R2"); wr(12, 6, "R2");
    wr(17, {16'd1, 16'd3}, "R2");
    wr(18, {16'd5, 16'd9}, "R2");
    wr(19, {16'd2, 16'd0}, "R2");
    rd_check(1, 32'd10, "R2");
    rd_check(9, 32'd6, "R2");
    rd_check(18, {16'd5, 16'd9}, "R2");
    rd_check(13, 32'd0, "R2");
    rd_check(16, 32'd0, "R2");
  endtask

  task automatic t_master;
    wr(0, 32'h1, "R11");
    rd_check(0, 32'h1, "R2");
    for (int k = 0; k < NFS; k++) fs_cnt[k] = 0;
    for (int i = 0; i < 120; i++) step(1'b0, "R3 R4 R5 R7 R8");
    check(fs_cnt[0] == 2, "R7", $sformatf("fsync0 pulses actual %0d expected 2", fs_cnt[0]));
    for (int k = 1; k < NFS; k++)
      check(fs_cnt[k] == 2, "R8", $sformatf("fsync%0d pulses actual %0d expected 2", k, fs_cnt[k]));
    for (int i = 0; i < 23; i++) step(1'b1, "R3 R4 R5");
  endtask

  task automatic t_shadow;
    wr(1, 12, "R10");
    wr(5, 8, "R10");
    wr(6, 11, "R10");
    wr(10, 12, "R10");
    for (int i = 0; i < 150; i++) step(1'b1, "R10");
  endtask

  task automatic t_polarity;
    wr(0, 32'hD, "R6");
    for (int i = 0; i < 150; i++) step(1'b0, "R6");
  endtask

  task automatic t_slave;
    wr(0, 32'h3, "R9");
    for (int k = 0; k < NFS; k++) fs_cnt[k] = 0;
    for (int i = 0; i < 400; i++) step((i % 3) != 0 && (i % 7) != 5, "R9");
    check(fs_cnt[0] >= 1, "R9", $sformatf("fsync0 pulses actual %0d expected >=1", fs_cnt[0]));
  endtask

  task automatic t_disable;
    wr(0, 32'h0, "R11");
    for (int i = 0; i < 4; i++) step(1'b1, "R11");
    wr(0, 32'h1, "R11");
    for (int i = 0; i < 30; i++) step(1'b0, "R11");
  endtask

  initial begin
    pend = '{ht: 2200, vt: 1125, ha: 1920, va: 1080, hsb: 2008, hse: 2052,
             vsb: 1084, vse: 1089, hbb: 1920, hbe: 2200, vbb: 1080, vbe: 1125,
             slave: 1'b0, hlow: 1'b0, vlow: 1'b0, fph: '{0, 0, 0, 0}, fpv: '{0, 0, 0, 0}};
    cur = pend;
    run_p = 1'b0; mh = 0; mv = 0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset;
    t_regs;
    t_master;
    t_shadow;
    t_polarity;
    t_slave;
    t_disable;
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end
endmodule